// File: doc/BRIEF.md
# Hash core message input parser

This block is the input controller at the front of a hash core. It pulls W-bit words from a passive FIFO through a ready/read handshake. It decodes a length-prefixed, segmented message stream and hands the message data to the hashing datapath as blocks of BW words.

Each segment opens with a header word. The header carries the segment's padded length in bits and a flag that marks the message's final segment. Only a final segment has a second word after its header, which holds the unpadded length in bits. The parser marks the first block of every message and the closing block of every message. With the closing block it presents the unpadded length, for use by a later padding stage.

One block can wait at the output while the next block is assembled. This lets input reading overlap the hashing of the current block. Protocol violations raise a sticky error and freeze input reading until reset.

Top module: `msg_parser`

## Requirements
- R1: `src_read` is high only in a cycle where `src_ready` is high, and each such cycle consumes exactly one word.
- R2: A header word holds the final-segment flag in bit W-1 and the padded segment length in bits in bits W-2..0. The segment supplies that length divided by W data words. A non-final header with length 0 carries no data, and the next word is another header.
- R3: When the header flag is 1, the next word is the unpadded length in bits, and the data words follow it. The closing block of the message has `blk_last`=1 and shows that length on `blk_bitlen`.
- R4: When the header flag is 0, the data words follow the header directly, and another header is expected afterwards. Blocks that do not close a message have `blk_last`=0 and `blk_bitlen`=0.
- R5: The k-th data word of a block (k counted from 0, in arrival order) sits in `blk_data[k*W +: W]`. A closing block with fewer than BW words is zero-filled in its upper words. Blocks never span segment boundaries of a final segment.
- R6: `blk_first` is 1 on the first block after reset and on the first block after every closing block, and 0 otherwise.
- R7: A non-final header whose length is not a multiple of BW*W bits sets `err`. Lengths that are multiples leave `err` at 0.
- R8: A final segment sets `err` in any of these cases: the unpadded length is 0, the padded length gives zero words, or the padded length is not a multiple of W.
- R9: `err` stays high until reset, and no word is read while it is high.
- R10: While `blk_valid`=1 and `blk_ready`=0, the outputs `blk_valid`, `blk_data`, `blk_last` and `blk_bitlen` hold their values.
- R11: With `blk_ready` held low, the parser accepts words until one block waits at the output and a second complete block is held inside. It then stalls.
- R12: After reset, `blk_valid`, `err` and `src_read` are 0 until words arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_ready | input | 1 | Input FIFO holds a word |
| din | input | W | Word at the head of the input FIFO |
| src_read | output | 1 | Pops the head word |
| blk_ready | input | 1 | Datapath accepts the presented block |
| blk_valid | output | 1 | A block is presented |
| blk_data | output | W*BW | Block words, first word lowest |
| blk_first | output | 1 | Block opens a message |
| blk_last | output | 1 | Block closes a message |
| blk_bitlen | output | W | Unpadded length in bits, on closing blocks |
| err | output | 1 | Sticky protocol error |

## Verification
The hardest case to reach is the full stall. In that case, one block is held at the output and a second finished block sits in the assembly register, so reading stops exactly ten words into a final segment. The stimulus reaches this case by holding `blk_ready` low while a twelve-word final segment sits in the source. It then counts the consumed words before releasing the sink. Every combination of zero to two non-final segments and final segments of one to nine words runs twice. The first run is at full rate. The second run uses sink and source gaps at coprime periods, so that both handshakes stall in every phase of block assembly.

// File: rtl/msg_parser.sv
module msg_parser #(
  parameter int W  = 16,
  parameter int BW = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            src_ready,
  input  logic [W-1:0]    din,
  output logic            src_read,
  input  logic            blk_ready,
  output logic            blk_valid,
  output logic [W*BW-1:0] blk_data,
  output logic            blk_first,
  output logic            blk_last,
  output logic [W-1:0]    blk_bitlen,
  output logic            err
);
  localparam int LW = $clog2(W);
  localparam int LB = $clog2(W*BW);
  localparam int IW = (BW > 1) ? $clog2(BW) : 1;
  localparam int CW = W - 1;

  typedef enum logic [1:0] {S_HDR, S_PRE, S_DAT} st_t;
  st_t st;

  logic [CW-1:0]   rem;
  logic            seg_last;
  logic [W-1:0]    pre;
  logic [IW-1:0]   idx;
  logic [W*BW-1:0] asm_d, fill;
  logic            asm_full, asm_first, asm_last, first_pend;
  logic [W-1:0]    asm_len;

  wire move = asm_full & (~blk_valid | blk_ready);
  wire take = src_ready & ~err & ((st != S_DAT) | ~asm_full | move);
  assign src_read = take;

  wire          hdr_last  = din[W-1];
  wire [CW-1:0] hdr_len   = din[CW-1:0];
  wire [CW-1:0] hdr_words = hdr_len >> LW;
  wire hdr_bad = hdr_last ? ((hdr_words == '0) | (hdr_len[LW-1:0] != '0))
                          : (hdr_len[LB-1:0] != '0);
  wire end_seg  = (rem == CW'(1));
  wire msg_end  = seg_last & end_seg;
  wire blk_done = (idx == IW'(BW-1)) | msg_end;

  always_comb begin
    fill = (idx == '0) ? '0 : asm_d;
    for (int k = 0; k < BW; k++)
      if (idx == IW'(k)) fill[k*W +: W] = din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_HDR;
      err <= 1'b0;
      rem <= '0;
      seg_last <= 1'b0;
      pre <= '0;
      idx <= '0;
      asm_d <= '0;
      asm_full <= 1'b0;
      asm_first <= 1'b0;
      asm_last <= 1'b0;
      asm_len <= '0;
      first_pend <= 1'b1;
      blk_valid <= 1'b0;
      blk_data <= '0;
      blk_first <= 1'b0;
      blk_last <= 1'b0;
      blk_bitlen <= '0;
    end else begin
      if (move) begin
        blk_valid  <= 1'b1;
        blk_data   <= asm_d;
        blk_first  <= asm_first;
        blk_last   <= asm_last;
        blk_bitlen <= asm_len;
        asm_full   <= 1'b0;
      end else if (blk_ready) begin
        blk_valid <= 1'b0;
      end
      if (take) begin
        case (st)
          S_HDR: begin
            if (hdr_bad) err <= 1'b1;
            else begin
              seg_last <= hdr_last;
              rem <= hdr_words;
              if (hdr_last) st <= S_PRE;
              else if (hdr_words != '0) st <= S_DAT;
            end
          end
          S_PRE: begin
            if (din == '0) err <= 1'b1;
            else begin
              pre <= din;
              st <= S_DAT;
            end
          end
          default: begin
            asm_d <= fill;
            rem <= rem - CW'(1);
            if (end_seg) st <= S_HDR;
            if (blk_done) begin
              idx <= '0;
              asm_full <= 1'b1;
              asm_first <= first_pend;
              asm_last <= msg_end;
              asm_len <= msg_end ? pre : '0;
              first_pend <= msg_end;
            end else begin
              idx <= idx + IW'(1);
            end
          end
        endcase
      end
    end
  end
endmodule

module msg_parser_chk #(
  parameter int W  = 16,
  parameter int BW = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            src_ready,
  input logic            src_read,
  input logic            blk_ready,
  input logic            blk_valid,
  input logic [W*BW-1:0] blk_data,
  input logic            blk_last,
  input logic [W-1:0]    blk_bitlen,
  input logic            err
);
  a_r1_read_needs_ready: assert property (@(posedge clk) disable iff (rst)
    src_read |-> src_ready);
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (rst)
    err |=> err);
  a_r9_no_read_in_err: assert property (@(posedge clk) disable iff (rst)
    err |-> !src_read);
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (blk_valid && !blk_ready) |=> (blk_valid && $stable(blk_data)
      && $stable(blk_last) && $stable(blk_bitlen)));
  a_r3_len_on_last: assert property (@(posedge clk) disable iff (rst)
    (blk_valid && blk_last) |-> (blk_bitlen != '0));
  a_r4_len_zero_otherwise: assert property (@(posedge clk) disable iff (rst)
    (blk_valid && !blk_last) |-> (blk_bitlen == '0));
endmodule

bind msg_parser msg_parser_chk #(.W(W), .BW(BW)) u_chk (
  .clk(clk), .rst(rst), .src_ready(src_ready), .src_read(src_read),
  .blk_ready(blk_ready), .blk_valid(blk_valid), .blk_data(blk_data),
  .blk_last(blk_last), .blk_bitlen(blk_bitlen), .err(err));

// File: tb/msg_parser_tb.sv
module msg_parser_tb;
  localparam int W = 16, BW = 4, CLK_NS = 10;

  logic clk = 0, rst = 1;
  logic src_ready, src_read, blk_ready, blk_valid, blk_first, blk_last, err;
  logic [W-1:0] din, blk_bitlen;
  logic [W*BW-1:0] blk_data;

  msg_parser #(.W(W), .BW(BW)) u_dut (.*);

  always #(CLK_NS/2) clk = ~clk;

  logic [W-1:0] mem [0:2047];
  int wr_ptr = 0, rd_ptr = 0;
  bit src_en = 1, gap_mode = 0, sink_off = 0;
  int cyc = 0, tests = 0, fails = 0, bad_read = 0, hold_bad = 0;

  assign src_ready = src_en && (rd_ptr < wr_ptr);
  assign din = mem[rd_ptr % 2048];

  logic [W*BW-1:0] cap_data [0:511], exp_data [0:511];
  logic cap_first [0:511], cap_last [0:511], exp_first [0:511], exp_last [0:511];
  logic [W-1:0] cap_len [0:511], exp_len [0:511];
  int cap_n = 0, exp_n = 0;
  logic [W*BW-1:0] eb, prev_data;
  int ei = 0;
  bit efirst = 1, prev_hold = 0;
  int val = 1;

  always @(negedge clk) begin
    cyc++;
    blk_ready = !sink_off && (!gap_mode || (cyc % 3) != 0);
    src_en = !gap_mode || (cyc % 5) != 1;
  end

  always @(posedge clk) begin
    if (rst) begin
      rd_ptr <= 0;
      cap_n <= 0;
      prev_hold <= 0;
    end else begin
      if (src_read) begin
        if (!src_ready) bad_read++;
        rd_ptr <= rd_ptr + 1;
      end
      if (prev_hold && (!blk_valid || blk_data != prev_data)) hold_bad++;
      prev_hold <= blk_valid && !blk_ready;
      prev_data <= blk_data;
      if (blk_valid && blk_ready) begin
        cap_data[cap_n]  <= blk_data;
        cap_first[cap_n] <= blk_first;
        cap_last[cap_n]  <= blk_last;
        cap_len[cap_n]   <= blk_bitlen;
        cap_n <= cap_n + 1;
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not end, actual cycles %0d expected fewer", cyc);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic chk(bit ok, string tag, int act, int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic push(logic [W-1:0] w);
    mem[wr_ptr] = w;
    wr_ptr++;
  endtask

  function automatic logic [W-1:0] hdr(bit l, int len);
    return {l, 15'(len)};
  endfunction

  task automatic add_exp(logic [W-1:0] d, bit is_end, int bp);
    eb[ei*W +: W] = d;
    ei++;
    if (ei == BW || is_end) begin
      exp_data[exp_n] = eb;
      exp_first[exp_n] = efirst;
      exp_last[exp_n] = is_end;
      exp_len[exp_n] = is_end ? W'(bp) : '0;
      exp_n++;
      efirst = is_end;
      eb = '0;
      ei = 0;
    end
  endtask

  task automatic do_reset();
    rst = 1;
    wr_ptr = 0;
    exp_n = 0;
    efirst = 1;
    eb = '0;
    ei = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;
  endtask

  task automatic nonfinal(int nb);
    push(hdr(0, nb * BW * W));
    for (int j = 0; j < nb * BW; j++) begin
      push(W'(val));
      add_exp(W'(val), 0, 0);
      val++;
    end
  endtask

  task automatic final_seg(int f);
    int bp;
    bp = f * W - 3;
    push(hdr(1, f * W));
    push(W'(bp));
    for (int j = 0; j < f; j++) begin
      push(W'(val));
      add_exp(W'(val), j == f - 1, bp);
      val++;
    end
  endtask

  task automatic wait_blocks(int lim);
    int n;
    n = 0;
    while (cap_n < exp_n && n < lim) begin
      @(posedge clk);
      n++;
    end
    repeat (10) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic compare();
    chk(cap_n == exp_n, "R2 block count", cap_n, exp_n);
    for (int i = 0; i < exp_n && i < cap_n; i++) begin
      chk(cap_data[i] == exp_data[i], "R5 block words", i, i);
      chk(cap_first[i] == exp_first[i], "R6 first flag", int'(cap_first[i]), int'(exp_first[i]));
      chk(cap_last[i] == exp_last[i], "R3/R4 last flag R3 R4", int'(cap_last[i]), int'(exp_last[i]));
      chk(cap_len[i] == exp_len[i], "R3 unpadded length", int'(cap_len[i]), int'(exp_len[i]));
    end
  endtask

  initial begin
    blk_ready = 1;
    do_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!blk_valid, "R12 valid after reset", int'(blk_valid), 0);
    chk(!err, "R12 err after reset", int'(err), 0);
    chk(!src_read, "R12 no read when empty", int'(src_read), 0);

    for (int gm = 0; gm < 2; gm++) begin
      do_reset();
      gap_mode = gm[0];
      for (int s = 0; s < 3; s++)
        for (int f = 1; f <= 9; f++) begin
          for (int q = 0; q < s; q++) nonfinal((q + f) % 3);
          final_seg(f);
        end
      wait_blocks(20000);
      compare();
      chk(rd_ptr == wr_ptr, "R1 all words consumed", rd_ptr, wr_ptr);
      chk(bad_read == 0, "R1 read without ready", bad_read, 0);
      chk(hold_bad == 0, "R10 output held while stalled", hold_bad, 0);
      chk(!err, "R7 block-multiple lengths accepted", int'(err), 0);
    end
    gap_mode = 0;

    do_reset();
    sink_off = 1;
    final_seg(12);
    repeat (40) @(posedge clk);
    @(negedge clk);
    chk(rd_ptr == 2 + 2 * BW, "R11 stall after two blocks", rd_ptr, 2 + 2 * BW);
    chk(blk_valid, "R11 first block waiting", int'(blk_valid), 1);
    chk(blk_data == exp_data[0], "R11 waiting block content", 0, 0);
    sink_off = 0;
    wait_blocks(200);
    compare();

    do_reset();
    push(hdr(0, 2 * W));
    for (int j = 0; j < 6; j++) push(W'(j + 1));
    repeat (20) @(posedge clk);
    @(negedge clk);
    chk(err, "R7 non-multiple segment", int'(err), 1);
    chk(rd_ptr == 1, "R9 reads stop on error", rd_ptr, 1);
    chk(!blk_valid, "R9 no block on error", int'(blk_valid), 0);

    do_reset();
    push(hdr(1, 2 * W));
    push('0);
    for (int j = 0; j < 4; j++) push(W'(j + 1));
    repeat (20) @(posedge clk);
    @(negedge clk);
    chk(err, "R8 zero unpadded length", int'(err), 1);
    chk(rd_ptr == 2, "R9 reads stop after length word", rd_ptr, 2);

    do_reset();
    push(hdr(1, 0));
    push(W'(5));
    repeat (20) @(posedge clk);
    @(negedge clk);
    chk(err, "R8 empty final segment", int'(err), 1);
    chk(rd_ptr == 1, "R9 reads stop after header", rd_ptr, 1);

    do_reset();
    push(hdr(1, 2 * W + 8));
    push(W'(20));
    repeat (20) @(posedge clk);
    @(negedge clk);
    chk(err, "R8 final length not word multiple", int'(err), 1);

    do_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!err, "R9 reset clears error", int'(err), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule